// File: doc/BRIEF.md
# Rename Comparator Signature Checker

This block sits in the rename stage of a three-wide pipeline. It holds the array of tag comparators that finds dependencies inside a rename group: sources of a later slot against destinations of an earlier slot, and destinations against each other. The array output drives dependency resolution in the same cycle. The block also reuses the array to catch soft errors in the tags without a second copy of the tag storage.

When a group of real instructions passes, the block stores the comparator result vector as a signature. Upstream then places a copy of that group's tags into the next empty pipeline slot. If that slot is a bubble, the copy runs through the same comparators. The fresh result vector is compared with the stored signature, and any difference produces a registered error pulse and sets a sticky error bit. Real instructions are never stalled. A signature that finds no bubble behind it is simply dropped, and a flush discards a pending signature.

Top module: `rename_sig_checker`

## Requirements
- R1: `depVec` bit i is 1 in the same cycle exactly when the two tags of pair i are equal. Tag field (s,f) sits at `tagsIn[(s*3+f)*TAG_W +: TAG_W]`, with f=0 destination, f=1 first source and f=2 second source. The pairs, bit 0 first, are: s1.src0/s0.dst, s1.src1/s0.dst, s2.src0/s0.dst, s2.src1/s0.dst, s2.src0/s1.dst, s2.src1/s1.dst, s1.dst/s0.dst, s2.dst/s0.dst, s2.dst/s1.dst.
- R2: A cycle with `inValid`=1 and `flush`=0 stores that cycle's `depVec` as the pending signature.
- R3: A cycle with `inValid`=0 right after a stored group is a replay cycle; its tag inputs carry the copy. `chkPulse` is 1 for the one cycle after it.
- R4: `errPulse` is 1 in the cycle after a replay whose `depVec` differs from the stored signature in any bit, and 0 after a replay that matches.
- R5: A real group followed by another real group yields no check; the newer group replaces the signature. Only the first bubble after a group checks; a second bubble yields no check.
- R6: `errPulse` lasts exactly one cycle per failed check.
- R7: `flush`=1 in a cycle discards any pending signature, suppresses a check in that cycle, and stores nothing even if `inValid`=1. The next bubble then yields no check.
- R8: `errSticky` rises with the first `errPulse` and stays 1 until reset, including through later clean checks.
- R9: After reset, `chkPulse`, `errPulse` and `errSticky` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush; drops the pending signature |
| inValid | input | 1 | 1 = real rename group, 0 = bubble |
| tagsIn | input | 3*3*TAG_W | Destination and source tags of three slots |
| depVec | output | 9 | Comparator results for dependency resolution |
| chkPulse | output | 1 | A replay comparison was made in the previous cycle |
| errPulse | output | 1 | The previous replay mismatched |
| errSticky | output | 1 | Some replay has mismatched since reset |

## Verification
The bench builds the block with its defaults: 7-bit tags, three slots and the nine-entry pair table. With 7-bit tags, every field of a group can hold a distinct value. Each comparator can therefore be set alone, all nine can be set at once, and a single flipped bit in one replayed source can be shown to change exactly one signature bit. Sequences cover clean and corrupted replays, groups back to back, double bubbles, and flushes on both real and bubble cycles.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int unsigned FIELDS_PER_SLOT = 3;
  localparam int unsigned PAIR_ENC_W      = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchSig;   // store current comparator vector
    logic doCheck;    // compare current vector against stored one
  } rscStrobeT;

endpackage

// File: rtl/rsc_cmp_array.sv
module rsc_cmp_array
  import rsc_pkg::*;
#(
  parameter int unsigned TAG_W     = 7,
  parameter int unsigned NUM_SLOTS = 3,
  parameter int unsigned NUM_CMP   = 9,
  // per entry {aSlot[1:0], aField[1:0], bSlot[1:0], bField[1:0]}, entry 0 at LSB
  parameter logic [NUM_CMP*PAIR_ENC_W-1:0] PAIR_TBL = {
    8'h84, 8'h80, 8'h40, 8'hA4, 8'h94, 8'hA0, 8'h90, 8'h60, 8'h50
  }
) (
  input  logic [NUM_SLOTS*FIELDS_PER_SLOT*TAG_W-1:0] tagsIn,
  output logic [NUM_CMP-1:0]                         cmpVec
);

  for (genvar i = 0; i < NUM_CMP; i++) begin : gCmp
    localparam int unsigned BASE = i * PAIR_ENC_W;
    localparam int unsigned A_SLOT = int'(PAIR_TBL[BASE+6 +: 2]);
    localparam int unsigned A_FLD  = int'(PAIR_TBL[BASE+4 +: 2]);
    localparam int unsigned B_SLOT = int'(PAIR_TBL[BASE+2 +: 2]);
    localparam int unsigned B_FLD  = int'(PAIR_TBL[BASE+0 +: 2]);
    localparam int unsigned A_IDX  = (A_SLOT * FIELDS_PER_SLOT + A_FLD) * TAG_W;
    localparam int unsigned B_IDX  = (B_SLOT * FIELDS_PER_SLOT + B_FLD) * TAG_W;

    assign cmpVec[i] = (tagsIn[A_IDX +: TAG_W] == tagsIn[B_IDX +: TAG_W]);
  end

endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      flush,
  input  logic      inValid,
  output rscStrobeT strb
);

  logic pendQ;

  // a real group arms; a bubble consumes; a flush wipes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= inValid & ~flush;
  end

  always_comb begin
    strb.latchSig = inValid & ~flush;
    strb.doCheck  = ~inValid & pendQ & ~flush;
  end

  AST_PEND_AFTER_REAL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !flush) |=> pendQ); // R2
  AST_FLUSH_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !pendQ); // R7

endmodule

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
#(
  parameter int unsigned NUM_CMP = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  rscStrobeT          strb,
  input  logic [NUM_CMP-1:0] cmpVec,
  output logic               chkPulse,
  output logic               errPulse,
  output logic               errSticky
);

  logic [NUM_CMP-1:0] sigQ;
  logic               sigDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sigQ <= '0;
    else if (strb.latchSig) sigQ <= cmpVec;
  end

  assign sigDiff = |(cmpVec ^ sigQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkPulse  <= 1'b0;
      errPulse  <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      chkPulse  <= strb.doCheck;
      errPulse  <= strb.doCheck & sigDiff;
      errSticky <= errSticky | (strb.doCheck & sigDiff);
    end
  end

  AST_CHECK_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    strb.doCheck |=> chkPulse); // R3
  AST_ERR_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> chkPulse); // R4
  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky); // R8
  AST_STICKY_WITH_ERR: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> errSticky); // R8

endmodule

// File: rtl/rename_sig_checker.sv
module rename_sig_checker
  import rsc_pkg::*;
#(
  parameter int unsigned TAG_W     = 7,
  parameter int unsigned NUM_SLOTS = 3,
  parameter int unsigned NUM_CMP   = 9,
  parameter logic [NUM_CMP*PAIR_ENC_W-1:0] PAIR_TBL = {
    8'h84, 8'h80, 8'h40, 8'hA4, 8'h94, 8'hA0, 8'h90, 8'h60, 8'h50
  },
  localparam int unsigned TAGS_W = NUM_SLOTS * FIELDS_PER_SLOT * TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              inValid,
  input  logic [TAGS_W-1:0] tagsIn,
  output logic [NUM_CMP-1:0] depVec,
  output logic              chkPulse,
  output logic              errPulse,
  output logic              errSticky
);

  rscStrobeT strb;

  rsc_cmp_array #(
    .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS), .NUM_CMP(NUM_CMP), .PAIR_TBL(PAIR_TBL)
  ) uCmp (
    .tagsIn(tagsIn),
    .cmpVec(depVec)
  );

  rsc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .strb(strb)
  );

  rsc_datapath #(.NUM_CMP(NUM_CMP)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpVec(depVec),
    .chkPulse(chkPulse), .errPulse(errPulse), .errSticky(errSticky)
  );

  AST_REAL_NO_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> !chkPulse); // R5
  AST_FLUSH_NO_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !chkPulse); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse); // R6
  AST_NO_DOUBLE_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    chkPulse |=> !chkPulse); // R5

endmodule

// File: tb/tb_rename_sig_checker.sv
`timescale 1ns/1ps
module tb_rename_sig_checker;

  localparam int TAG_W  = 7;
  localparam int TAGS_W = 9 * TAG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic inValid = 1'b0;
  logic [TAGS_W-1:0] tagsIn = '0;
  logic [8:0] depVec;
  logic chkPulse, errPulse, errSticky;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rename_sig_checker dut (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .tagsIn(tagsIn),
    .depVec(depVec), .chkPulse(chkPulse), .errPulse(errPulse), .errSticky(errSticky)
  );

  typedef struct {
    logic  chk;
    logic  err;
    logic  stk;
    string req;
  } expT;

  expT sbQ[$];
  expT cur;

  // bench reference state
  logic       refPend = 1'b0;
  logic [8:0] refSig = '0;
  logic       refStk = 1'b0;

  function automatic logic [TAGS_W-1:0] pack(input int d0, a0, b0, d1, a1, b1, d2, a2, b2);
    pack = {7'(b2), 7'(a2), 7'(d2), 7'(b1), 7'(a1), 7'(d1), 7'(b0), 7'(a0), 7'(d0)};
  endfunction

  function automatic logic [6:0] fld(input logic [TAGS_W-1:0] t, input int s, input int f);
    fld = t[(s*3+f)*TAG_W +: TAG_W];
  endfunction

  // dependency vector per R1 pair list
  function automatic logic [8:0] expDep(input logic [TAGS_W-1:0] t);
    logic [8:0] d;
    d[0] = fld(t,1,1) == fld(t,0,0);
    d[1] = fld(t,1,2) == fld(t,0,0);
    d[2] = fld(t,2,1) == fld(t,0,0);
    d[3] = fld(t,2,2) == fld(t,0,0);
    d[4] = fld(t,2,1) == fld(t,1,0);
    d[5] = fld(t,2,2) == fld(t,1,0);
    d[6] = fld(t,1,0) == fld(t,0,0);
    d[7] = fld(t,2,0) == fld(t,0,0);
    d[8] = fld(t,2,0) == fld(t,1,0);
    return d;
  endfunction

  task automatic chk1(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic fl, input logic [TAGS_W-1:0] t, input string req);
    logic [8:0] d;
    expT e;
    @(negedge clk);
    inValid = v; flush = fl; tagsIn = t;
    #1;
    d = expDep(t);
    chk1("R1", "depVec", 32'(depVec), 32'(d));
    e.chk = ~v & refPend & ~fl;
    e.err = e.chk & (d != refSig);
    refStk = refStk | e.err;
    e.stk = refStk;
    e.req = req;
    if (v && !fl) refSig = d;
    refPend = v & ~fl;
    sbQ.push_back(e);
  endtask

  // monitor: outputs after the edge that ends the driven cycle
  always @(negedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      cur = sbQ.pop_front();
      chk1(cur.req, "chkPulse", 32'(chkPulse), 32'(cur.chk));
      chk1(cur.req, "errPulse", 32'(errPulse), 32'(cur.err));
      chk1((cur.err ? "R8" : cur.req), "errSticky", 32'(errSticky), 32'(cur.stk));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [TAGS_W-1:0] tA, tAc, tZ, tS, tC;
    tA  = pack(5, 1, 2,  6, 5, 3,  7, 6, 5);
    tAc = pack(5, 1, 2,  6, 4, 3,  7, 6, 5);   // s1.src0 bit 0 flipped
    tZ  = pack(10, 11, 12, 13, 14, 15, 16, 17, 18);
    tS  = pack(9, 9, 9, 9, 9, 9, 9, 9, 9);
    tC  = pack(20, 21, 22, 20, 23, 24, 25, 20, 20);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk1("R9", "chkPulse", 32'(chkPulse), 0);
    chk1("R9", "errPulse", 32'(errPulse), 0);
    chk1("R9", "errSticky", 32'(errSticky), 0);

    // R1 patterns: none, all, mixed
    drive(1, 0, tZ, "R1");
    drive(1, 0, tS, "R1");
    drive(1, 0, tC, "R1");
    // R2/R3 clean replay, then R5 second bubble
    drive(1, 0, tA, "R2");
    drive(0, 0, tA, "R3");
    drive(0, 0, tA, "R5");
    // R4 corrupted replay, R6 pulse gone next cycle
    drive(1, 0, tA, "R2");
    drive(0, 0, tAc, "R4");
    drive(0, 0, tZ, "R6");
    // R5 back to back: newer group replaces signature
    drive(1, 0, tA, "R5");
    drive(1, 0, tC, "R5");
    drive(0, 0, tC, "R5");
    drive(1, 0, tC, "R5");
    drive(1, 0, tC, "R5");
    drive(0, 0, tA, "R5");
    // R7 flush on bubble, flush on real
    drive(1, 0, tA, "R7");
    drive(0, 1, tAc, "R7");
    drive(0, 0, tAc, "R7");
    drive(1, 1, tA, "R7");
    drive(0, 0, tAc, "R7");
    // R8 sticky survives clean check
    drive(1, 0, tS, "R8");
    drive(0, 0, tS, "R8");
    drive(0, 0, tZ, "R8");
    drive(0, 0, tZ, "R6");

    wait (sbQ.size() == 0);
    @(negedge clk);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule